// File: doc/BRIEF.md
# Threshold Trigger Detector

This block decides when a data-acquisition front end should capture an event. Each time a new conversion sample arrives it compares the sample's most significant bits with a programmable threshold. When the selected condition holds, it raises a one-cycle trigger pulse and a sticky triggered flag. The sample may be a signed (two's complement) or an unsigned (straight binary) code, as chosen by a format input. A two-bit mode selects one of four conditions: an upward crossing, a downward crossing, the sample above the threshold, or the sample below it.

The host enables the detector by holding the run input high, selecting the capture mode and pulling the active-low arm input low. While any of these conditions is missing, the detector is idle. In that state it cannot fire, its flag is clear and it forgets the sample history it holds for edge detection. Each arming period gives at most one trigger pulse. The flag then holds the event until the host disarms the detector or stops the run.

Top module: `thresh_trig_det`

## Requirements
- R1: Only the upper 8 bits of the 12-bit sample (bits 11..4) are compared with the 8-bit threshold. Bits 3..0 have no effect on any decision.
- R2: With `fmt_signed`=1 the sample's upper bits and the threshold are compared as two's complement numbers. With `fmt_signed`=0 they are compared as unsigned numbers.
- R3: With `level_sel`=0 and `dir_up`=1 (upward crossing), a valid sample fires when its value is greater than the threshold and the previous valid sample's value was not greater than the threshold.
- R4: With `level_sel`=0 and `dir_up`=0 (downward crossing), a valid sample fires when its value is less than the threshold and the previous valid sample's value was not less than the threshold.
- R5: With `level_sel`=1, a valid sample fires when its value is greater than the threshold (`dir_up`=1) or less than it (`dir_up`=0). A value equal to the threshold never fires.
- R6: The detector is enabled only while `run_en`=1, `burst_sel`=1 and `arm_n`=0 are all sampled at the same edge. At an edge where it is not enabled, no pulse is produced, the flag clears and the stored previous sample is discarded.
- R7: In the crossing modes, the first valid sample after the detector becomes enabled cannot fire. In the level modes it can.
- R8: `trig_pulse` is high for exactly the one cycle after the clock edge that captures the firing sample. Within one enabled period only the first firing sample gives a pulse. `trig_seen` rises with that pulse and stays high while the detector stays enabled.
- R9: A synchronous active-low reset clears `trig_pulse`, `trig_seen` and the stored previous sample.
- R10: A cycle with `smp_valid`=0 neither fires nor replaces the stored previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new conversion sample |
| smp_data | input | 12 | Conversion sample |
| thr_code | input | 8 | Threshold, in the same format as the sample |
| dir_up | input | 1 | 1: upward or above; 0: downward or below |
| level_sel | input | 1 | 1: level condition; 0: crossing condition |
| fmt_signed | input | 1 | 1: two's complement codes; 0: straight binary |
| arm_n | input | 1 | Active-low arm |
| run_en | input | 1 | Acquisition running |
| burst_sel | input | 1 | Capture (burst) mode selected |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_seen | output | 1 | Sticky triggered flag |

## Verification
The sample patterns step up to the threshold, land on it and then pass it, so an equal value is told apart from one just above or below. Codes that differ only in their four low bits show that those bits are ignored. Codes with the top bit set are run under both formats, which tells the signed comparison from the unsigned one. Gaps in the valid strobe, disarm pulses and a sample already past the threshold on the first cycle of arming show where the edge history is kept and where it is cleared. A long random phase, with the arm, run and mode bits changing, is compared on every clock against a reference model.

// File: rtl/trig_pkg.sv
// Package trig_pkg
// Shared widths and the encoding of the trigger condition select.
// Assumes that the sample is at least as wide as the threshold.
package trig_pkg;
    localparam int unsigned SAMPLE_W = 12;
    localparam int unsigned THRESH_W = 8;

    // {level_sel, dir_up}
    typedef enum logic [1:0] {
        COND_CROSS_DOWN = 2'b00,
        COND_CROSS_UP   = 2'b01,
        COND_LVL_BELOW  = 2'b10,
        COND_LVL_ABOVE  = 2'b11
    } trig_cond_e;
endpackage

// File: rtl/trig_cmp.sv
// Module trig_cmp
// Magnitude comparison of a value with the threshold, either as a signed
// or as an unsigned number. Purely combinational.
// Assumes that both operands have the same width and the same format.
module trig_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] thr,
    input  logic         is_signed,
    output logic         gt,
    output logic         lt
);
    // Select the signed or the unsigned ordering.
    always_comb begin
        if (is_signed) begin
            gt = $signed(val) > $signed(thr);
            lt = $signed(val) < $signed(thr);
        end else begin
            gt = val > thr;
            lt = val < thr;
        end
    end

    // R2: a value cannot be both above and below the threshold
    always_comb begin
        a_r2_exclusive: assert (!(gt && lt));
    end
endmodule

// File: rtl/trig_hist.sv
// Module trig_hist
// Holds the compared bits of the last valid sample for crossing detection.
// Assumes that clr has priority over load.
module trig_hist #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         q_ok
);
    // Capture the sample, or forget it on reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q    <= '0;
            q_ok <= 1'b0;
        end else if (load) begin
            q    <= d;
            q_ok <= 1'b1;
        end
    end

    // R10: without a load the stored sample is kept
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> $stable(q) && $stable(q_ok));
endmodule

// File: rtl/trig_fire_ctl.sv
// Module trig_fire_ctl
// Decides whether a sample meets the selected condition and produces the
// pulse and the sticky flag.
// Assumes that the compare results for the current and the previous sample
// are computed against the same threshold.
module trig_fire_ctl
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       smp_valid,
    input  trig_cond_e cond,
    input  logic       cur_gt,
    input  logic       cur_lt,
    input  logic       prev_gt,
    input  logic       prev_lt,
    input  logic       prev_ok,
    output logic       pulse,
    output logic       seen
);
    logic fire;

    // Evaluate the selected condition for this sample.
    always_comb begin
        unique case (cond)
            COND_LVL_ABOVE:  fire = cur_gt;
            COND_LVL_BELOW:  fire = cur_lt;
            COND_CROSS_UP:   fire = prev_ok && cur_gt && !prev_gt;
            COND_CROSS_DOWN: fire = prev_ok && cur_lt && !prev_lt;
            default:         fire = 1'b0;
        endcase
        fire = fire && smp_valid;
    end

    // Register a single pulse per enabled period and hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pulse <= 1'b0;
            seen  <= 1'b0;
        end else begin
            pulse <= fire && !seen;
            if (fire) begin
                seen <= 1'b1;
            end
        end
    end

    // R8: the pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R8: the pulse always comes with the flag
    a_r8_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> seen);
    // R8: the flag is sticky while enabled
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && en) |=> seen);
    // R6: disable clears everything
    a_r6_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!seen && !pulse));
    // R7: a crossing needs a stored sample
    a_r7_edge_needs_hist: assert property (@(posedge clk) disable iff (!rst_n)
        (en && smp_valid && !prev_ok && !cond[1]) |=> !pulse);
    // R10: no pulse without a valid sample
    a_r10_pulse_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !smp_valid) |=> !pulse);
endmodule

// File: rtl/thresh_trig_det.sv
// Module thresh_trig_det
// Threshold trigger detector: slices the upper bits of each sample and
// compares them, and the stored previous sample, with the threshold.
// It also fires a single pulse per arming and holds a triggered flag.
// Assumes that SMP_W is greater than THR_W.
module thresh_trig_det
    import trig_pkg::*;
#(
    parameter int unsigned SMP_W = SAMPLE_W,
    parameter int unsigned THR_W = THRESH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [THR_W-1:0] thr_code,
    input  logic             dir_up,
    input  logic             level_sel,
    input  logic             fmt_signed,
    input  logic             arm_n,
    input  logic             run_en,
    input  logic             burst_sel,
    output logic             trig_pulse,
    output logic             trig_seen
);
    localparam int unsigned DROP_W = SMP_W - THR_W;
    localparam int unsigned N_CMP  = 2;

    logic             det_en;
    logic [THR_W-1:0] cur_top;
    logic [THR_W-1:0] prev_top;
    logic             prev_ok;
    logic             unused_low_bits;
    logic [THR_W-1:0] cmp_in [N_CMP];
    logic [N_CMP-1:0] cmp_gt;
    logic [N_CMP-1:0] cmp_lt;
    trig_cond_e       cond;

    // Combine the run, burst-mode and active-low arm controls.
    assign det_en  = run_en && burst_sel && !arm_n;
    // R1: keep only the most significant bits of the sample.
    assign cur_top = smp_data[SMP_W-1 -: THR_W];
    assign unused_low_bits = ^smp_data[DROP_W-1:0];
    assign cond    = trig_cond_e'({level_sel, dir_up});
    assign cmp_in[0] = cur_top;
    assign cmp_in[1] = prev_top;

    trig_hist #(.W(THR_W)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!det_en),
        .load  (det_en && smp_valid),
        .d     (cur_top),
        .q     (prev_top),
        .q_ok  (prev_ok)
    );

    // One comparator for the current sample and one for the previous sample.
    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        trig_cmp #(.W(THR_W)) u_cmp (
            .val       (cmp_in[i]),
            .thr       (thr_code),
            .is_signed (fmt_signed),
            .gt        (cmp_gt[i]),
            .lt        (cmp_lt[i])
        );
    end

    trig_fire_ctl u_fire (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (det_en),
        .smp_valid (smp_valid),
        .cond      (cond),
        .cur_gt    (cmp_gt[0]),
        .cur_lt    (cmp_lt[0]),
        .prev_gt   (cmp_gt[1]),
        .prev_lt   (cmp_lt[1]),
        .prev_ok   (prev_ok),
        .pulse     (trig_pulse),
        .seen      (trig_seen)
    );

    // R9: reset clears the outputs
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!trig_pulse && !trig_seen));
    // R5: a level sample equal to the threshold does not fire
    a_r5_equal_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (level_sel && smp_valid && (cur_top == thr_code) && !trig_seen) |=> !trig_pulse);
endmodule

// File: tb/tb_thresh_trig_det.sv
module tb_thresh_trig_det;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [11:0] smp_data;
    logic [7:0]  thr_code;
    logic        dir_up, level_sel, fmt_signed, arm_n, run_en, burst_sel;
    logic        trig_pulse, trig_seen;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R9";
    bit    done     = 1'b0;

    // reference model state
    bit m_pulse = 0, m_seen = 0, m_hv = 0;
    int m_prev  = 0;

    always #2.5 clk = ~clk;

    thresh_trig_det dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr_code(thr_code), .dir_up(dir_up), .level_sel(level_sel),
        .fmt_signed(fmt_signed), .arm_n(arm_n), .run_en(run_en),
        .burst_sel(burst_sel), .trig_pulse(trig_pulse), .trig_seen(trig_seen)
    );

    function automatic int to_val(logic [7:0] c, bit sgn);
        if (sgn && c[7]) return int'(c) - 256;
        return int'(c);
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        int cur, t;
        bit gt, lt, pgt, plt, fire;
        if (!rst_n) begin
            m_pulse = 0; m_seen = 0; m_hv = 0; m_prev = 0;
        end else if (!(run_en && burst_sel && !arm_n)) begin
            m_pulse = 0; m_seen = 0; m_hv = 0;
        end else begin
            m_pulse = 0;
            if (smp_valid) begin
                cur = to_val(smp_data[11:4], fmt_signed);
                t   = to_val(thr_code, fmt_signed);
                gt = cur > t; lt = cur < t;
                pgt = m_prev > t; plt = m_prev < t;
                if (level_sel) fire = dir_up ? gt : lt;
                else fire = m_hv && (dir_up ? (gt && !pgt) : (lt && !plt));
                if (fire && !m_seen) begin m_pulse = 1; m_seen = 1; end
                m_prev = cur; m_hv = 1;
            end
        end
    end

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (trig_pulse !== m_pulse || trig_seen !== m_seen) begin
                n_fail++;
                $display("FAIL %s model: pulse=%0b seen=%0b expected pulse=%0b seen=%0b",
                         cur_req, trig_pulse, trig_seen, m_pulse, m_seen);
            end
        end
    end

    task automatic expect_out(input bit ep, input bit es, input string req);
        n_checks++;
        if (trig_pulse !== ep || trig_seen !== es) begin
            n_fail++;
            $display("FAIL %s: pulse=%0b seen=%0b expected pulse=%0b seen=%0b",
                     req, trig_pulse, trig_seen, ep, es);
        end
    endtask

    // drive one cycle from a falling edge, return at the next falling edge
    task automatic step(input bit v, input logic [11:0] d);
        smp_valid = v; smp_data = d;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic setup(input bit lvl, input bit up, input bit sgn, input logic [7:0] t);
        arm_n = 1'b1;
        step(0, 12'h000);
        level_sel = lvl; dir_up = up; fmt_signed = sgn; thr_code = t;
        arm_n = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_valid = 0; smp_data = 0; thr_code = 0; dir_up = 0;
        level_sel = 0; fmt_signed = 0; arm_n = 1; run_en = 1; burst_sel = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(0, 0, "R9 reset");

        // R3 upward crossing, unsigned, threshold 0x80
        cur_req = "R3";
        setup(0, 1, 0, 8'h80);
        step(1, 12'h700); expect_out(0, 0, "R3 below");
        step(1, 12'h800); expect_out(0, 0, "R3 equal");
        step(1, 12'h810); expect_out(1, 1, "R3 crossing");
        cur_req = "R8";
        step(1, 12'h900); expect_out(0, 1, "R8 pulse one cycle");
        step(1, 12'h700); step(1, 12'h900); expect_out(0, 1, "R8 one pulse per arming");

        // R6 disarm, then level-above samples while disarmed
        cur_req = "R6";
        arm_n = 1'b1; level_sel = 1;
        step(0, 12'h000); expect_out(0, 0, "R6 disarm clears flag");
        step(1, 12'hF00); expect_out(0, 0, "R6 disarmed no fire");
        arm_n = 1'b0; burst_sel = 1'b0;
        step(1, 12'hF00); expect_out(0, 0, "R6 not burst");
        burst_sel = 1'b1; run_en = 1'b0;
        step(1, 12'hF00); expect_out(0, 0, "R6 not running");
        run_en = 1'b1;

        // R7 first sample after arming
        cur_req = "R7";
        setup(0, 1, 0, 8'h80);
        step(1, 12'h900); expect_out(0, 0, "R7 first sample no edge");
        setup(1, 1, 0, 8'h80);
        step(1, 12'h900); expect_out(1, 1, "R7 level fires on first");

        // R1 low bits ignored
        cur_req = "R1";
        setup(1, 1, 0, 8'h80);
        step(1, 12'h80F); expect_out(0, 0, "R1 low bits ignored");
        step(1, 12'h810); expect_out(1, 1, "R1 upper bits above");

        // R2 signed vs unsigned
        cur_req = "R2";
        setup(1, 1, 1, 8'h10);
        step(1, 12'h800); expect_out(0, 0, "R2 signed negative");
        step(1, 12'h200); expect_out(1, 1, "R2 signed positive");
        setup(1, 1, 0, 8'h10);
        step(1, 12'h800); expect_out(1, 1, "R2 unsigned large");

        // R4 downward crossing
        cur_req = "R4";
        setup(0, 0, 0, 8'h40);
        step(1, 12'h500); step(1, 12'h400); expect_out(0, 0, "R4 equal");
        step(1, 12'h3F0); expect_out(1, 1, "R4 crossing");

        // R5 level below and equal
        cur_req = "R5";
        setup(1, 0, 0, 8'h40);
        step(1, 12'h40A); expect_out(0, 0, "R5 equal no fire");
        step(1, 12'h300); expect_out(1, 1, "R5 below");

        // R10 invalid cycles keep history
        cur_req = "R10";
        setup(0, 1, 0, 8'h80);
        step(1, 12'h900);
        step(0, 12'h100); expect_out(0, 0, "R10 invalid no fire");
        step(0, 12'h100);
        step(1, 12'h900); expect_out(0, 0, "R10 history kept");
        step(1, 12'h100); step(1, 12'h900); expect_out(1, 1, "R10 crossing after");

        // random phase against the model
        cur_req = "R8 random";
        for (int i = 0; i < 3000; i++) begin
            smp_valid  = ($urandom_range(0, 3) != 0);
            smp_data   = 12'($urandom_range(0, 4095));
            if ($urandom_range(0, 40) == 0) thr_code = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 60) == 0) begin
                level_sel = 1'($urandom_range(0, 1)); dir_up = 1'($urandom_range(0, 1));
                fmt_signed = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 30) == 0) arm_n = ~arm_n;
            run_en    = ($urandom_range(0, 100) != 0);
            burst_sel = ($urandom_range(0, 100) != 0);
            @(posedge clk);
            @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule